// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block produces DMA requests from external interrupt lines instead of from a peripheral. It holds several independent generator channels. Each channel picks one of the shared trigger lines and chooses which transition of that line counts as an event: a rising edge, a falling edge, or either. When an event occurs on an enabled channel, the channel issues a burst of requests. The burst has one more request than the value in the channel's count field.

Each request uses a request/acknowledge handshake. A request line stays high until the DMA controller acknowledges it. The line then goes low for one cycle before the next request of the burst is raised. An event that arrives while a burst is still running does not start anything and sets a sticky overrun flag. Clearing a channel's enable stops its burst and clears its overrun flag.

The request outputs feed the input pool of a request multiplexer. The trigger lines are asynchronous to the clock, so each one passes through two flops before edges are detected.

Top module: `dmagen_top`

## Requirements
- R1: After reset every request output and every overrun flag is 0.
- R2: A channel whose enable bit is 0 raises no request, whatever its trigger line does.
- R3: Only the trigger line whose index equals the channel's select field launches a burst; activity on any other line has no effect on that channel.
- R4: The 2-bit polarity field selects the event: 2'b01 rising edge, 2'b10 falling edge, 2'b11 both edges, 2'b00 no event.
- R5: Each event launches exactly (count field + 1) requests.
- R6: A raised request stays high until an acknowledge is seen with the request high; an acknowledge while the request is low has no effect.
- R7: After an acknowledge the request is low for at least one cycle, and the next request of the burst is raised only after that.
- R8: An event on a channel whose burst is in progress (including the cycle of its last acknowledge) starts nothing new and sets that channel's overrun flag, which stays set until the enable bit is cleared.
- R9: Clearing the enable bit drops the request and the overrun flag on the next clock edge and abandons the rest of the burst; re-enabling does not resume it.
- R10: A trigger change applied before clock edge 1 raises the request after clock edge 3 (two synchronizer flops, then the burst register), not earlier.
- R11: The count field is captured when the event is accepted; changing it during a burst does not change that burst's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NUM_TRIG | Asynchronous external trigger lines |
| en_i | input | NUM_CH | Per-channel enable |
| sel_i | input | NUM_CH*SEL_W | Per-channel trigger line index, channel c at bits [c*SEL_W +: SEL_W] |
| pol_i | input | NUM_CH*2 | Per-channel event polarity, channel c at bits [2c +: 2] |
| cnt_i | input | NUM_CH*CNT_W | Per-channel burst length minus one |
| ack_i | input | NUM_CH | Per-channel DMA acknowledge |
| req_o | output | NUM_CH | Per-channel DMA request |
| ovr_o | output | NUM_CH | Per-channel sticky overrun flag |

## Verification
The collision of interest is a trigger event reaching the burst logic in the same cycle as the acknowledge of a burst's final request. The bench provokes it by setting both polarities and letting the trigger fall. Two cycles later it raises the acknowledge of the only request, so that the acknowledge and the synchronized edge reach the same clock edge. The outcome counts as correct when the request drops, the overrun flag is set, and no further request follows. The bench also checks that an abort through the enable bit wins over an acknowledge that is pending.

// File: rtl/dmagen_pkg.sv
package dmagen_pkg;

    // Event polarity encoding
    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } pol_e;

    // Burst sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_GAP  = 2'b10
    } burst_st_e;

    // Decide whether a transition from prev to cur is an event for pol
    function automatic logic edge_hit(input pol_e pol, input logic cur, input logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (pol)
            POL_RISE: edge_hit = rise;
            POL_FALL: edge_hit = fall;
            POL_BOTH: edge_hit = rise | fall;
            default:  edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dmagen_sync.sv
module dmagen_sync #(
    parameter int NUM_TRIG = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] trig_i,
    output logic [NUM_TRIG-1:0] sync_o,
    output logic [NUM_TRIG-1:0] prev_o
);
    // Per line: two metastability flops plus one history flop
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_line
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= trig_i[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign sync_o[i] = s2_q;
        assign prev_o[i] = s3_q;
    end
endmodule

// File: rtl/dmagen_edge.sv
module dmagen_edge
    import dmagen_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    parameter int SEL_W    = $clog2(NUM_TRIG)
) (
    input  logic [NUM_TRIG-1:0] sync_i,
    input  logic [NUM_TRIG-1:0] prev_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [1:0]          pol_i,
    output logic                hit_o
);
    localparam logic [SEL_W:0] LINES = NUM_TRIG[SEL_W:0];

    logic in_range;
    logic cur, prv;

    always_comb begin
        in_range = ({1'b0, sel_i} < LINES);
        cur      = 1'b0;
        prv      = 1'b0;
        if (in_range) begin
            cur = sync_i[sel_i];
            prv = prev_i[sel_i];
        end
        hit_o = edge_hit(pol_e'(pol_i), cur, prv);
    end
endmodule

// File: rtl/dmagen_burst.sv
module dmagen_burst
    import dmagen_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             ovr_o
);
    burst_st_e        st_q;
    logic [CNT_W-1:0] left_q;   // requests still to issue after the current one

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            st_q   <= ST_IDLE;
            left_q <= '0;
            req_o  <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (hit_i) begin
                        st_q   <= ST_REQ;
                        left_q <= cnt_i;
                        req_o  <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (hit_i) ovr_o <= 1'b1;
                    if (ack_i) begin
                        req_o <= 1'b0;
                        if (left_q == '0) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q   <= ST_GAP;
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (hit_i) ovr_o <= 1'b1;
                    st_q  <= ST_REQ;
                    req_o <= 1'b1;
                end
                default: begin
                    st_q  <= ST_IDLE;
                    req_o <= 1'b0;
                end
            endcase
        end
    end

    // R6: request held while not acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        req_o && !ack_i && en_i |=> req_o);

    // R7: acknowledge always forces a low cycle
    p_ack_gap_r7: assert property (@(posedge clk) disable iff (rst)
        req_o && ack_i |=> !req_o);

    // R9: disable clears request and overrun on the next edge
    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !req_o && !ovr_o);

    // R8: overrun flag is sticky while enabled
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovr_o && en_i |=> ovr_o);

    // R4: a burst only starts from idle on an accepted event
    p_start_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) && $past(st_q) == ST_IDLE |-> $past(hit_i));
endmodule

// File: rtl/dmagen_top.sv
module dmagen_top #(
    parameter int NUM_CH   = 4,
    parameter int NUM_TRIG = 8,
    parameter int CNT_W    = 5,
    localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_TRIG-1:0]     trig_i,
    input  logic [NUM_CH-1:0]       en_i,
    input  logic [NUM_CH*SEL_W-1:0] sel_i,
    input  logic [NUM_CH*2-1:0]     pol_i,
    input  logic [NUM_CH*CNT_W-1:0] cnt_i,
    input  logic [NUM_CH-1:0]       ack_i,
    output logic [NUM_CH-1:0]       req_o,
    output logic [NUM_CH-1:0]       ovr_o
);
    logic [NUM_TRIG-1:0] sync_w;
    logic [NUM_TRIG-1:0] prev_w;

    dmagen_sync #(.NUM_TRIG(NUM_TRIG)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_w;

        dmagen_edge #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_edge (
            .sync_i (sync_w),
            .prev_i (prev_w),
            .sel_i  (sel_i[c*SEL_W +: SEL_W]),
            .pol_i  (pol_i[c*2 +: 2]),
            .hit_o  (hit_w)
        );

        dmagen_burst #(.CNT_W(CNT_W)) u_burst (
            .clk   (clk),
            .rst   (rst),
            .en_i  (en_i[c]),
            .hit_i (hit_w),
            .cnt_i (cnt_i[c*CNT_W +: CNT_W]),
            .ack_i (ack_i[c]),
            .req_o (req_o[c]),
            .ovr_o (ovr_o[c])
        );
    end

    // R1: outputs quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (req_o == '0) && (ovr_o == '0));
endmodule

// File: tb/sim_dmagen_top.sv
module sim_dmagen_top;
    localparam int NCH = 4;
    localparam int NTR = 8;
    localparam int CW  = 5;
    localparam int SW  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NTR-1:0]    trig = '0;
    logic [NCH-1:0]    en = '0;
    logic [NCH*SW-1:0] sel = '0;
    logic [NCH*2-1:0]  pol = '0;
    logic [NCH*CW-1:0] cnt = '0;
    logic [NCH-1:0]    ack = '0;
    logic [NCH-1:0]    req;
    logic [NCH-1:0]    ovr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dmagen_top #(.NUM_CH(NCH), .NUM_TRIG(NTR), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .trig_i(trig), .en_i(en), .sel_i(sel),
        .pol_i(pol), .cnt_i(cnt), .ack_i(ack), .req_o(req), .ovr_o(ovr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int ch, input bit e, input int s, input int p, input int n);
        en[ch]            = e;
        sel[ch*SW +: SW]  = SW'(s);
        pol[ch*2 +: 2]    = 2'(p);
        cnt[ch*CW +: CW]  = CW'(n);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Act as the DMA: acknowledge each request, count them, and watch the gap
    task automatic serve(input int ch, input int idle_limit, output int n, output int bad_gap);
        int idle = 0;
        bit acked = 0;
        n = 0;
        bad_gap = 0;
        while (idle < idle_limit) begin
            @(negedge clk);
            ack[ch] = 1'b0;
            if (acked && req[ch]) bad_gap++;
            acked = 0;
            if (req[ch]) begin
                n++;
                ack[ch] = 1'b1;
                acked = 1;
                idle = 0;
            end else begin
                idle++;
            end
        end
        ack[ch] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req after reset", int'(req), 0);
        chk("R1 ovr after reset", int'(ovr), 0);
    endtask

    task automatic t_latency_hold();
        int n, g;
        setup(0, 1, 2, 1, 0);
        cycles(2);
        trig[2] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 req not yet after two edges", int'(req[0]), 0);
        @(negedge clk);
        chk("R10 req after third edge", int'(req[0]), 1);
        cycles(8);
        chk("R6 req held without ack", int'(req[0]), 1);
        serve(0, 6, n, g);
        chk("R5 count 0 gives one request", n, 1);
        trig[2] = 1'b0;
        serve(0, 8, n, g);
        chk("R4 rising polarity ignores fall", n, 0);
    endtask

    task automatic t_burst();
        int n, g;
        setup(0, 1, 2, 1, 4);
        trig[2] = 1'b1;
        serve(0, 8, n, g);
        chk("R5 count 4 gives five requests", n, 5);
        chk("R7 low cycle after each ack", g, 0);
        trig[2] = 1'b0;
        serve(0, 8, n, g);
    endtask

    task automatic t_polarity();
        int n, g;
        setup(0, 1, 2, 2, 0);
        trig[2] = 1'b1;
        serve(0, 8, n, g);
        chk("R4 falling polarity ignores rise", n, 0);
        trig[2] = 1'b0;
        serve(0, 8, n, g);
        chk("R4 falling polarity on fall", n, 1);
        setup(0, 1, 2, 3, 1);
        trig[2] = 1'b1;
        serve(0, 8, n, g);
        chk("R4 both edges on rise", n, 2);
        trig[2] = 1'b0;
        serve(0, 8, n, g);
        chk("R4 both edges on fall", n, 2);
        setup(0, 1, 2, 0, 0);
        trig[2] = 1'b1;
        serve(0, 8, n, g);
        trig[2] = 1'b0;
        serve(0, 8, n, g);
        chk("R4 polarity none gives nothing", n, 0);
    endtask

    task automatic t_select();
        int n, g;
        setup(0, 1, 2, 1, 0);
        setup(1, 1, 5, 1, 0);
        trig[5] = 1'b1;
        cycles(6);
        chk("R3 other line leaves channel 0 idle", int'(req[0]), 0);
        serve(1, 8, n, g);
        chk("R3 selected line drives channel 1", n, 1);
        trig[5] = 1'b0;
        setup(1, 0, 5, 1, 0);
        cycles(4);
    endtask

    task automatic t_disabled();
        int n, g;
        setup(0, 0, 2, 3, 0);
        trig[2] = 1'b1;
        serve(0, 8, n, g);
        trig[2] = 1'b0;
        serve(0, 8, n, g);
        chk("R2 disabled channel gives nothing", n, 0);
    endtask

    task automatic t_ack_idle();
        int n, g;
        setup(0, 1, 2, 1, 1);
        ack[0] = 1'b1;
        cycles(4);
        ack[0] = 1'b0;
        trig[2] = 1'b1;
        cycles(3);
        chk("R6 req raised after idle ack", int'(req[0]), 1);
        serve(0, 8, n, g);
        chk("R6 idle ack did not consume requests", n, 2);
        trig[2] = 1'b0;
        cycles(4);
    endtask

    task automatic t_overrun();
        int n, g;
        setup(0, 1, 2, 3, 2);
        trig[2] = 1'b1;
        cycles(3);
        chk("R8 burst started", int'(req[0]), 1);
        trig[2] = 1'b0;
        cycles(4);
        chk("R8 overrun set by edge during burst", int'(ovr[0]), 1);
        serve(0, 8, n, g);
        chk("R8 ignored edge adds no requests", n, 3);
        chk("R8 overrun sticky after burst", int'(ovr[0]), 1);
        en[0] = 1'b0;
        cycles(1);
        chk("R8 overrun cleared by disable", int'(ovr[0]), 0);
    endtask

    task automatic t_abort();
        int n, g;
        setup(0, 1, 2, 1, 5);
        trig[2] = 1'b1;
        cycles(3);
        chk("R9 burst running", int'(req[0]), 1);
        en[0] = 1'b0;
        ack[0] = 1'b1;
        cycles(1);
        ack[0] = 1'b0;
        chk("R9 req dropped one clock after disable", int'(req[0]), 0);
        en[0] = 1'b1;
        serve(0, 8, n, g);
        chk("R9 burst not resumed", n, 0);
        trig[2] = 1'b0;
        cycles(4);
    endtask

    task automatic t_cnt_latch();
        int n, g;
        setup(0, 1, 2, 1, 1);
        trig[2] = 1'b1;
        cycles(3);
        cnt[0 +: CW] = CW'(6);
        serve(0, 8, n, g);
        chk("R11 count captured at event", n, 2);
        trig[2] = 1'b0;
        cycles(4);
    endtask

    task automatic t_collide();
        int n, g;
        setup(0, 1, 2, 3, 0);
        trig[2] = 1'b1;
        cycles(3);
        chk("R8 single request up", int'(req[0]), 1);
        trig[2] = 1'b0;
        cycles(2);
        ack[0] = 1'b1;
        cycles(1);
        ack[0] = 1'b0;
        chk("R8 final ack drops req", int'(req[0]), 0);
        chk("R8 edge at final ack sets overrun", int'(ovr[0]), 1);
        serve(0, 8, n, g);
        chk("R8 edge at final ack starts nothing", n, 0);
        en[0] = 1'b0;
        cycles(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency_hold();
        t_burst();
        t_polarity();
        t_select();
        t_disabled();
        t_ack_idle();
        t_overrun();
        t_abort();
        t_cnt_latch();
        t_collide();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule